// File: doc/BRIEF.md
# Line-Locked Timing Pulse Generator

This block produces three per-line control pulses for a video front end. The first is a sample window for the sync-tip gain loop. The second is a clamp window that sits on the back porch. The third is a horizontal sync output. It runs on the pixel clock, which is the output sample rate clock. A line counter restarts at zero on every strobe that marks the falling edge of incoming horizontal sync. Each pulse is high while the count lies inside a window. The window is set by a programmable start count and end count, and it may wrap through the end of the line.

While the line-lock loop is still acquiring, the gain and clamp pulses both take the gain window's placement, so they overlap. This acquisition mode starts after reset and after any strobe that signals a change of video standard or a reload of the subcarrier ratio. When lock is reported, the clamp pulse moves to its own programmed placement. If lock is later lost, the block goes back to acquisition at the next line start. A plain write port programs the six window counts, and no write is ever refused or stalled. A write changes a staging copy only. The copy becomes active at the next sync edge, so a line never runs with half of an update.

Top module: `line_pulse_gen`

## Requirements
- R1: A high `hsync_fall` sets the line count to 0 at that clock edge. After that the count rises by one per clock. Each output is registered, so it reflects the count and settings held during the previous cycle.
- R2: The count stops at 1023 when no sync edge arrives, and all three outputs stay low while it is stopped there. After reset the count starts stopped at 1023, and the outputs are low during reset.
- R3: For a window whose start is less than its end, the pulse is high for counts start through end-1.
- R4: For a window whose start is greater than its end, the pulse is high for counts at or above start and for counts below end. A window whose start equals its end never goes high.
- R5: A write with `cfg_wr_en` high stores `cfg_wr_data` in the staging register picked by `cfg_wr_addr`: 0 gain start, 1 gain end, 2 clamp start, 3 clamp end, 4 sync start, 5 sync end. Staged values become active only at a `hsync_fall` edge. Writes to addresses 6 and 7 have no effect.
- R6: After reset, both the staged and the active registers hold gain 0x2F8/0x008, clamp 0x028/0x040 and sync 0x020/0x050.
- R7: Reset, or a high `acq_restart`, puts the block in acquisition mode. In that mode `gain_win` and `clamp_win` both follow the gain start and end values.
- R8: In acquisition mode, a high `pll_locked` ends acquisition at the next clock edge, unless `acq_restart` is also high. After that, `clamp_win` follows the clamp values.
- R9: If `pll_locked` is low while the block is out of acquisition, the block re-enters acquisition at the next `hsync_fall` edge and not before.
- R10: `hsync_out` always follows the sync start and end values, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel (output sample rate) clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_fall | input | 1 | One-cycle strobe at the falling edge of incoming horizontal sync |
| pll_locked | input | 1 | Line-lock loop reports stable lock |
| acq_restart | input | 1 | One-cycle strobe for a standard change or subcarrier ratio reload |
| cfg_wr_en | input | 1 | Write strobe for the window registers |
| cfg_wr_addr | input | 3 | Window register select |
| cfg_wr_data | input | 10 | Count value to stage |
| gain_win | output | 1 | Sync-tip gain sampling window |
| clamp_win | output | 1 | Back-porch clamp window |
| hsync_out | output | 1 | Regenerated horizontal sync pulse |

## Verification
Each output is one register stage after the count, the active settings and the mode flag. The count for pixel k after a sync strobe therefore shows on the outputs one edge after the edge that loads that count. A staged write first becomes visible on the cycle after the next strobe edge. A change in lock or restart moves the clamp output one cycle after the edge where the mode flag changes. The bench drives inputs on the falling clock edge and, before each rising edge, predicts the outputs from its own model of the count, settings and mode. It compares those predictions at the following falling edge, so every output is sampled exactly one register stage after the state it depends on.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int CNT_W    = 10;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 6;
  localparam int NUM_CH   = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_GAIN_S  = 3'd0,
    REG_GAIN_E  = 3'd1,
    REG_CLAMP_S = 3'd2,
    REG_CLAMP_E = 3'd3,
    REG_SYNC_S  = 3'd4,
    REG_SYNC_E  = 3'd5
  } reg_idx_e;

  // Channel order of the output pulses
  typedef enum int {CH_GAIN = 0, CH_CLAMP = 1, CH_SYNC = 2} ch_e;

  // Square-pixel 640-wide line placement; element 0 is gain start
  localparam logic [NUM_REGS-1:0][CNT_W-1:0] DEFAULT_VALS = {
    10'h050, 10'h020,   // sync end, sync start
    10'h040, 10'h028,   // clamp end, clamp start
    10'h008, 10'h2F8    // gain end, gain start
  };
endpackage

// File: rtl/lpg_line_counter.sv
module lpg_line_counter #(
  parameter int W = lpg_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_start,
  output logic [W-1:0] count,
  output logic         saturated
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= CNT_MAX;
    else if (line_start)       count <= '0;
    else if (count != CNT_MAX) count <= count + 1'b1;
  end

  assign saturated = (count == CNT_MAX);

  a_r1_zero_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (count == '0));

  a_r2_hold_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    (saturated && !line_start) |=> saturated);

  a_r1_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!saturated && !line_start) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/lpg_win_regs.sv
module lpg_win_regs #(
  parameter int W  = lpg_pkg::CNT_W,
  parameter int N  = lpg_pkg::NUM_REGS,
  parameter int AW = lpg_pkg::ADDR_W,
  parameter logic [N-1:0][W-1:0] INIT = lpg_pkg::DEFAULT_VALS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_start,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [W-1:0]        wr_data,
  output logic [N-1:0][W-1:0] active
);
  logic [N-1:0][W-1:0] staged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= INIT;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en && (wr_addr == AW'(i))) staged[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          active <= INIT;
    else if (line_start) active <= staged;
  end

  a_r5_active_only_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(active));

  a_r5_copy_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (active == $past(staged)));
endmodule

// File: rtl/lpg_acq_ctrl.sv
module lpg_acq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic lock,
  input  logic restart,
  output logic acq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          acq <= 1'b1;
    else if (restart)                    acq <= 1'b1;
    else if (acq && lock)                acq <= 1'b0;
    else if (!acq && !lock && line_start) acq <= 1'b1;
  end

  a_r7_restart_enters_acq: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> acq);

  a_r8_lock_leaves_acq: assert property (@(posedge clk) disable iff (!rst_n)
    (acq && lock && !restart) |=> !acq);

  a_r9_wait_for_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq && !restart && !line_start) |=> !acq);
endmodule

// File: rtl/lpg_window.sv
module lpg_window #(
  parameter int W = lpg_pkg::CNT_W
) (
  input  logic [W-1:0] count,
  input  logic         saturated,
  input  logic [W-1:0] win_start,
  input  logic [W-1:0] win_end,
  output logic         hit
);
  logic above_start, below_end;

  assign above_start = (count >= win_start);
  assign below_end   = (count <  win_end);

  always_comb begin
    if (saturated)                 hit = 1'b0;
    else if (win_start < win_end)  hit = above_start && below_end;
    else if (win_start > win_end)  hit = above_start || below_end;
    else                           hit = 1'b0;
  end
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen #(
  parameter int CNT_W  = lpg_pkg::CNT_W,
  parameter int ADDR_W = lpg_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_fall,
  input  logic              pll_locked,
  input  logic              acq_restart,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [CNT_W-1:0]  cfg_wr_data,
  output logic              gain_win,
  output logic              clamp_win,
  output logic              hsync_out
);
  import lpg_pkg::*;

  localparam int NR = lpg_pkg::NUM_REGS;
  localparam int NC = lpg_pkg::NUM_CH;

  logic [CNT_W-1:0]           count;
  logic                       saturated;
  logic [NR-1:0][CNT_W-1:0]   regs;
  logic                       acq;
  logic [NC-1:0][CNT_W-1:0]   sel_start, sel_end;
  logic [NC-1:0]              hit, pulse_q;

  lpg_line_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .line_start(hsync_fall),
    .count(count), .saturated(saturated)
  );

  lpg_win_regs #(.W(CNT_W), .N(NR), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .line_start(hsync_fall),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
    .active(regs)
  );

  lpg_acq_ctrl u_acq (
    .clk(clk), .rst_n(rst_n), .line_start(hsync_fall),
    .lock(pll_locked), .restart(acq_restart), .acq(acq)
  );

  // Window placement per channel; clamp borrows the gain window while acquiring
  always_comb begin
    sel_start[CH_GAIN]  = regs[REG_GAIN_S];
    sel_end[CH_GAIN]    = regs[REG_GAIN_E];
    sel_start[CH_CLAMP] = acq ? regs[REG_GAIN_S] : regs[REG_CLAMP_S];
    sel_end[CH_CLAMP]   = acq ? regs[REG_GAIN_E] : regs[REG_CLAMP_E];
    sel_start[CH_SYNC]  = regs[REG_SYNC_S];
    sel_end[CH_SYNC]    = regs[REG_SYNC_E];
  end

  for (genvar c = 0; c < NC; c++) begin : g_ch
    lpg_window #(.W(CNT_W)) u_win (
      .count(count), .saturated(saturated),
      .win_start(sel_start[c]), .win_end(sel_end[c]),
      .hit(hit[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= hit;
  end

  assign gain_win  = pulse_q[CH_GAIN];
  assign clamp_win = pulse_q[CH_CLAMP];
  assign hsync_out = pulse_q[CH_SYNC];

  a_r2_quiet_when_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    saturated |=> (pulse_q == '0));

  a_r7_overlap_in_acq: assert property (@(posedge clk) disable iff (!rst_n)
    acq |=> (gain_win == clamp_win));

  a_r4_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[REG_SYNC_S] == regs[REG_SYNC_E]) |=> !hsync_out);
endmodule

// File: tb/line_pulse_gen_tb.sv
module line_pulse_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       d_hs = 1'b0, d_lock = 1'b0, d_restart = 1'b0, d_wr = 1'b0;
  logic [2:0] d_addr = '0;
  logic [9:0] d_data = '0;
  logic       gain_win, clamp_win, hsync_out;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic [9:0]      m_cnt;
  logic [5:0][9:0] m_stage, m_act;
  bit              m_acq;

  always #2 clk = ~clk;

  line_pulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_fall(d_hs), .pll_locked(d_lock),
    .acq_restart(d_restart), .cfg_wr_en(d_wr), .cfg_wr_addr(d_addr),
    .cfg_wr_data(d_data), .gain_win(gain_win), .clamp_win(clamp_win),
    .hsync_out(hsync_out)
  );

  function automatic bit win(int c, int s, int e);
    if (c == 1023) return 0;
    if (s < e) return (c >= s) && (c < e);
    if (s > e) return (c >= s) || (c < e);
    return 0;
  endfunction

  task automatic check(bit act, bit exp, string name, string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (model count %0d)",
               tag, name, act, exp, m_cnt);
    end
  endtask

  task automatic model_reset();
    m_cnt   = 10'h3FF;
    m_stage = {10'h050, 10'h020, 10'h040, 10'h028, 10'h008, 10'h2F8};
    m_act   = m_stage;
    m_acq   = 1;
  endtask

  // Inputs are set; predict outputs after the next rising edge, advance model, compare
  task automatic tick(string tag);
    bit eg, ec, es;
    logic [5:0][9:0] nxt_act;
    int cs, ce;
    cs = m_acq ? int'(m_act[0]) : int'(m_act[2]);
    ce = m_acq ? int'(m_act[1]) : int'(m_act[3]);
    eg = win(m_cnt, m_act[0], m_act[1]);
    ec = win(m_cnt, cs, ce);
    es = win(m_cnt, m_act[4], m_act[5]);
    nxt_act = d_hs ? m_stage : m_act;
    if (d_wr && d_addr < 3'd6) m_stage[d_addr] = d_data;
    m_act = nxt_act;
    if (d_restart)                     m_acq = 1;
    else if (m_acq && d_lock)          m_acq = 0;
    else if (!m_acq && !d_lock && d_hs) m_acq = 1;
    m_cnt = d_hs ? 10'd0 : ((m_cnt == 10'h3FF) ? m_cnt : m_cnt + 10'd1);
    @(negedge clk);
    check(gain_win,  eg, "gain_win",  tag);
    check(clamp_win, ec, "clamp_win", tag);
    check(hsync_out, es, "hsync_out", tag);
    d_hs = 0; d_restart = 0; d_wr = 0;
  endtask

  task automatic run_line(int len, string tag);
    d_hs = 1;
    for (int i = 0; i < len; i++) tick(tag);
  endtask

  task automatic write(logic [2:0] a, logic [9:0] v);
    d_wr = 1; d_addr = a; d_data = v;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R2: outputs low in reset
    check(gain_win, 0, "gain_win", "R2 reset");
    check(clamp_win, 0, "clamp_win", "R2 reset");
    check(hsync_out, 0, "hsync_out", "R2 reset");
    rst_n = 1;
    for (int i = 0; i < 5; i++) tick("R2 after reset");

    // R6 defaults, R7 overlap in acquisition, R4 wrapping gain window, R10 sync
    d_lock = 0;
    for (int l = 0; l < 3; l++) run_line(780, "R6 R7 R4 R10");

    // R8 lock moves clamp to its own window; R1 counting
    d_lock = 1;
    for (int l = 0; l < 3; l++) run_line(780, "R8 R1");

    // R5 mid-line writes stage; active at next edge; addresses 6,7 ignored
    d_hs = 1; tick("R5");
    for (int i = 0; i < 100; i++) tick("R5");
    write(3'd0, 10'h33F); tick("R5");
    write(3'd1, 10'h000); tick("R5");
    write(3'd2, 10'h037); tick("R5");
    write(3'd3, 10'h052); tick("R5");
    write(3'd4, 10'h33B); tick("R5");
    write(3'd5, 10'h060); tick("R5");
    write(3'd6, 10'h000); tick("R5 ignored addr");
    write(3'd7, 10'h3FF); tick("R5 ignored addr");
    for (int i = 0; i < 700; i++) tick("R5 old values");
    for (int l = 0; l < 3; l++) run_line(858, "R5 R3 R10");

    // R4 wrap and empty windows
    d_hs = 1; tick("R4");
    write(3'd0, 10'h300); tick("R4");
    write(3'd1, 10'h010); tick("R4");
    write(3'd2, 10'h050); tick("R4");
    write(3'd3, 10'h050); tick("R4");
    write(3'd4, 10'h3F0); tick("R4");
    write(3'd5, 10'h020); tick("R4");
    for (int i = 0; i < 900; i++) tick("R4");
    for (int l = 0; l < 3; l++) run_line(1010, "R4 R10");

    // R9 lock lost mid-line: stays out of acquisition until next edge
    d_hs = 1; tick("R9");
    for (int i = 0; i < 400; i++) tick("R9");
    d_lock = 0;
    for (int i = 0; i < 600; i++) tick("R9");
    for (int l = 0; l < 2; l++) run_line(1000, "R9");

    // R7 restart while locked returns to acquisition; R8 relock
    d_lock = 1;
    run_line(1000, "R8");
    d_hs = 1; tick("R7");
    for (int i = 0; i < 20; i++) tick("R7");
    d_lock = 0; d_restart = 1; tick("R7 restart");
    for (int i = 0; i < 500; i++) tick("R7");
    d_lock = 1;
    for (int i = 0; i < 400; i++) tick("R8");

    // R2 no edges: count stops, outputs quiet
    for (int i = 0; i < 1200; i++) tick("R2 saturate");
    run_line(300, "R1 after saturate");

    // Random mix of line lengths, writes, lock and restart
    for (int l = 0; l < 40; l++) begin
      int len;
      len = $urandom_range(100, 1200);
      d_hs = 1;
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 99) < 2) write(3'($urandom_range(0, 7)), 10'($urandom_range(0, 1023)));
        if ($urandom_range(0, 199) == 0) d_lock = ~d_lock;
        if ($urandom_range(0, 499) == 0) d_restart = 1;
        tick("R1 R3 random");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule